// File: doc/BRIEF.md
# Sixteen-Bit ALU with Operand-B Modifier

This block is the arithmetic-logic unit of a 16-bit load/store processor core. Operand A comes straight from the register file. Operand B first passes through a modifier stage. That stage can hand B on unchanged, invert it, negate it, force it to zero, or replace it with a small unsigned constant taken from the instruction. The modified B and operand A then go to one of seven functions: add, subtract, AND, NOR, XOR, a one-position shift, or a one-position rotate.

The unit is fully combinational from its operand inputs to its result and flag outputs. The only storage is a 4-bit status register. It captures the flags on a clock edge when the flag-enable input is high. The adder is an explicit two-level carry-lookahead structure built from 4-bit groups.

Top module: `alu16`

## Requirements
- R1: `bmod_i` selects what replaces operand B. The codes are: 0 leaves B as it is, 1 inverts every bit, 2 gives the two's complement, 3 gives zero, and 4 gives `const_i` zero-extended to 16 bits. Codes 5 to 7 act like code 0.
- R2: With `fn_i` = 0 (ADD), `result_o` = (A + modified B + `cin_i`) mod 2^16, and carry is the carry out of bit 15.
- R3: With `fn_i` = 1 (SUB), `result_o` = A + ~(modified B) + 1. Here `cin_i` is ignored. Carry is 1 exactly when there is no borrow, which means A ≥ modified B taken as unsigned numbers.
- R4: For ADD and SUB, the overflow flag is 1 when A and the value actually fed to the adder have the same sign bit and the result's sign bit differs from it. Otherwise it is 0.
- R5: With `fn_i` = 2, 3 and 4 the result is A AND B, NOT(A OR B) and A XOR B respectively, using the modified B. Carry and overflow are 0, and `cin_i` has no effect.
- R6: With `fn_i` = 5 (SHIFT), A moves one position: left when `dir_i` = 0, and right (logical) when `dir_i` = 1. Zero fills the vacated bit, carry takes the bit shifted out, and overflow is 0.
- R7: With `fn_i` = 6 (ROTATE), A rotates one position in the direction chosen by `dir_i`. Carry takes the bit that wraps around, and overflow is 0.
- R8: The flags are `flags_o`[0] carry, [1] zero (all result bits 0), [2] negative (result bit 15) and [3] overflow. With `fn_i` = 7 the result is 0 and carry and overflow are 0.
- R9: `status_o` is 0 while `rst_ni` is low. At a rising clock edge it loads `flags_o` when `flag_en_i` = 1 and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the status register |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_i | input | 16 | Operand A |
| b_i | input | 16 | Operand B before modification |
| fn_i | input | 3 | Function select |
| bmod_i | input | 3 | Operand-B modifier select |
| const_i | input | 8 | Constant used by modifier code 4 |
| dir_i | input | 1 | Shift/rotate direction, 1 = right |
| cin_i | input | 1 | Carry into bit 0 for ADD |
| flag_en_i | input | 1 | Status register load enable |
| result_o | output | 16 | ALU result |
| flags_o | output | 4 | Combinational flags {V,N,Z,C} |
| status_o | output | 4 | Registered flags |

## Verification
The arithmetic vectors are chosen to separate the flag outcomes:
- carries that ripple across all four lookahead groups, including the case of all ones plus a carry-in;
- signed overflow in both directions;
- subtraction with and without a borrow;
- equal operands, which must give a zero result.

Each modifier code is paired with an addition, so that an inverted, negated, zeroed or constant B yields a distinct sum. The constant cases include one where the constant alone carries out of bit 15. The logic functions use operands that would set carry or produce a result with no set bits, and the inputs include a high carry-in, which must have no effect. Shift and rotate each use a word with both end bits set, so the two directions and the fill-versus-wrap behaviour give different results. Directed steps then check the status register's load, hold and asynchronous reset.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
  typedef enum logic [2:0] {
    FN_ADD    = 3'd0,
    FN_SUB    = 3'd1,
    FN_AND    = 3'd2,
    FN_NOR    = 3'd3,
    FN_XOR    = 3'd4,
    FN_SHIFT  = 3'd5,
    FN_ROTATE = 3'd6,
    FN_NONE   = 3'd7
  } alu_fn_e;

  localparam logic [2:0] BM_PASS  = 3'd0;
  localparam logic [2:0] BM_INV   = 3'd1;
  localparam logic [2:0] BM_NEG   = 3'd2;
  localparam logic [2:0] BM_ZERO  = 3'd3;
  localparam logic [2:0] BM_CONST = 3'd4;

  localparam int NFLAGS = 4;
  localparam int FLG_C  = 0;
  localparam int FLG_Z  = 1;
  localparam int FLG_N  = 2;
  localparam int FLG_V  = 3;
endpackage

// File: rtl/alu16_bmod.sv
module alu16_bmod
  import alu16_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int CW    = 8
) (
  input  logic [WIDTH-1:0] b_i,
  input  logic [2:0]       mode_i,
  input  logic [CW-1:0]    const_i,
  output logic [WIDTH-1:0] b_o
);
  always_comb begin
    case (mode_i)
      BM_INV:   b_o = ~b_i;
      BM_NEG:   b_o = (~b_i) + WIDTH'(1);
      BM_ZERO:  b_o = '0;
      BM_CONST: b_o = WIDTH'(const_i);
      default:  b_o = b_i;
    endcase
  end

  always_comb begin
    if (mode_i == BM_NEG) begin
      assert_neg_sum_zero_R1: assert (WIDTH'(b_o + b_i) == '0)
        else $error("negated B does not cancel B");
    end
    if (mode_i == BM_INV) begin
      assert_inv_disjoint_R1: assert ((b_o & b_i) == '0)
        else $error("inverted B shares set bits with B");
    end
  end
endmodule

// File: rtl/alu16_cla_grp.sv
module alu16_cla_grp #(
  parameter int GW = 4
) (
  input  logic [GW-1:0] a_i,
  input  logic [GW-1:0] b_i,
  input  logic          c_i,
  output logic [GW-1:0] s_o,
  output logic          g_o,
  output logic          p_o
);
  logic [GW-1:0] p, g;
  logic [GW:0]   c;

  assign p = a_i ^ b_i;
  assign g = a_i & b_i;

  // group generate/propagate depend only on operands, never on c_i
  always_comb begin
    g_o = 1'b0;
    for (int i = 0; i < GW; i++) g_o = g[i] | (p[i] & g_o);
    p_o = &p;
  end

  // per-bit carries; flattened to sum-of-products per bit
  always_comb begin
    c[0] = c_i;
    for (int i = 0; i < GW; i++) c[i+1] = g[i] | (p[i] & c[i]);
    s_o = p ^ c[GW-1:0];
  end
endmodule

// File: rtl/alu16_cla.sv
module alu16_cla #(
  parameter int WIDTH = 16,
  parameter int GW    = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  localparam int NG = WIDTH / GW;

  logic [NG-1:0] grp_g, grp_p;
  logic [NG:0]   grp_c;

  // second-level carry generator
  always_comb begin
    grp_c[0] = cin_i;
    for (int j = 0; j < NG; j++) grp_c[j+1] = grp_g[j] | (grp_p[j] & grp_c[j]);
  end

  for (genvar j = 0; j < NG; j++) begin : g_grp
    alu16_cla_grp #(.GW(GW)) u_grp (
      .a_i (a_i[j*GW +: GW]),
      .b_i (b_i[j*GW +: GW]),
      .c_i (grp_c[j]),
      .s_o (sum_o[j*GW +: GW]),
      .g_o (grp_g[j]),
      .p_o (grp_p[j])
    );
  end

  assign cout_o = grp_c[NG];

  always_comb begin
    assert_cla_sum_R2: assert ({cout_o, sum_o} ==
                               ({1'b0, a_i} + {1'b0, b_i} + (WIDTH+1)'(cin_i)))
      else $error("lookahead sum mismatch");
  end
endmodule

// File: rtl/alu16.sv
module alu16
  import alu16_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int CW    = 8,
  parameter int GW    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WIDTH-1:0]  a_i,
  input  logic [WIDTH-1:0]  b_i,
  input  logic [2:0]        fn_i,
  input  logic [2:0]        bmod_i,
  input  logic [CW-1:0]     const_i,
  input  logic              dir_i,
  input  logic              cin_i,
  input  logic              flag_en_i,
  output logic [WIDTH-1:0]  result_o,
  output logic [NFLAGS-1:0] flags_o,
  output logic [NFLAGS-1:0] status_o
);
  localparam int MSB = WIDTH - 1;

  alu_fn_e        fn;
  logic [MSB:0]   b_mod, add_b, add_sum;
  logic           add_cin, add_cout;
  logic           carry, ovf;
  logic           is_sub;

  assign fn     = alu_fn_e'(fn_i);
  assign is_sub = (fn == FN_SUB);

  alu16_bmod #(.WIDTH(WIDTH), .CW(CW)) u_bmod (
    .b_i     (b_i),
    .mode_i  (bmod_i),
    .const_i (const_i),
    .b_o     (b_mod)
  );

  assign add_b   = is_sub ? ~b_mod : b_mod;
  assign add_cin = is_sub ? 1'b1   : cin_i;

  alu16_cla #(.WIDTH(WIDTH), .GW(GW)) u_cla (
    .a_i    (a_i),
    .b_i    (add_b),
    .cin_i  (add_cin),
    .sum_o  (add_sum),
    .cout_o (add_cout)
  );

  always_comb begin
    result_o = '0;
    carry    = 1'b0;
    ovf      = 1'b0;
    case (fn)
      FN_ADD, FN_SUB: begin
        result_o = add_sum;
        carry    = add_cout;
        ovf      = (a_i[MSB] == add_b[MSB]) && (add_sum[MSB] != a_i[MSB]);
      end
      FN_AND: result_o = a_i & b_mod;
      FN_NOR: result_o = ~(a_i | b_mod);
      FN_XOR: result_o = a_i ^ b_mod;
      FN_SHIFT: begin
        result_o = dir_i ? {1'b0, a_i[MSB:1]} : {a_i[MSB-1:0], 1'b0};
        carry    = dir_i ? a_i[0] : a_i[MSB];
      end
      FN_ROTATE: begin
        result_o = dir_i ? {a_i[0], a_i[MSB:1]} : {a_i[MSB-1:0], a_i[MSB]};
        carry    = dir_i ? a_i[0] : a_i[MSB];
      end
      default: ;
    endcase
  end

  always_comb begin
    flags_o        = '0;
    flags_o[FLG_C] = carry;
    flags_o[FLG_Z] = ~|result_o;
    flags_o[FLG_N] = result_o[MSB];
    flags_o[FLG_V] = ovf;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        status_o <= '0;
    else if (flag_en_i) status_o <= flags_o;
  end

  always_comb begin
    if (fn == FN_AND || fn == FN_NOR || fn == FN_XOR) begin
      assert_logic_flags_clear_R5: assert (!flags_o[FLG_C] && !flags_o[FLG_V])
        else $error("logic op left carry/overflow set");
    end
    if (fn == FN_SUB) begin
      assert_sub_no_borrow_R3: assert (flags_o[FLG_C] == (a_i >= b_mod))
        else $error("subtract carry disagrees with unsigned compare");
    end
    if (fn == FN_SHIFT && !dir_i) begin
      assert_shl_carry_R6: assert (flags_o[FLG_C] == a_i[MSB])
        else $error("left shift carry is not old MSB");
    end
    if (fn == FN_ROTATE) begin
      assert_rot_ones_kept_R7: assert ($countones(result_o) == $countones(a_i))
        else $error("rotate changed population count");
    end
  end

  assert_status_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_en_i |=> status_o == $past(flags_o))
    else $error("status did not load flags");

  assert_status_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_en_i |=> $stable(status_o))
    else $error("status changed without enable");
endmodule

// File: tb/alu16_bench.sv
module alu16_bench;
  typedef struct packed {
    logic [2:0]  fn;
    logic [2:0]  bm;
    logic [15:0] a;
    logic [15:0] b;
    logic [7:0]  k;
    logic        dir;
    logic        cin;
    logic [15:0] exp_r;
    logic [3:0]  exp_f;   // {V,N,Z,C}
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 3'd0, 16'h1234, 16'h0001, 8'h00, 1'b0, 1'b0, 16'h1235, 4'b0000}, // R2
    '{3'd0, 3'd0, 16'hFFFF, 16'h0000, 8'h00, 1'b0, 1'b1, 16'h0000, 4'b0011}, // R2 carry chain
    '{3'd0, 3'd0, 16'h7FFF, 16'h0001, 8'h00, 1'b0, 1'b0, 16'h8000, 4'b1100}, // R4
    '{3'd1, 3'd0, 16'h0005, 16'h0003, 8'h00, 1'b0, 1'b0, 16'h0002, 4'b0001}, // R3
    '{3'd1, 3'd0, 16'h0003, 16'h0005, 8'h00, 1'b0, 1'b0, 16'hFFFE, 4'b0100}, // R3 borrow
    '{3'd1, 3'd0, 16'h8000, 16'h0001, 8'h00, 1'b0, 1'b0, 16'h7FFF, 4'b1001}, // R4
    '{3'd1, 3'd0, 16'h0005, 16'h0005, 8'h00, 1'b0, 1'b1, 16'h0000, 4'b0011}, // R3 cin ignored
    '{3'd0, 3'd1, 16'h0010, 16'h00FF, 8'h00, 1'b0, 1'b0, 16'hFF10, 4'b0100}, // R1 invert
    '{3'd0, 3'd2, 16'h0010, 16'h0003, 8'h00, 1'b0, 1'b0, 16'h000D, 4'b0001}, // R1 negate
    '{3'd0, 3'd3, 16'h8001, 16'h1234, 8'h00, 1'b0, 1'b0, 16'h8001, 4'b0100}, // R1 zero
    '{3'd0, 3'd4, 16'h0100, 16'hAAAA, 8'hC8, 1'b0, 1'b0, 16'h01C8, 4'b0000}, // R1 const
    '{3'd0, 3'd4, 16'hFF01, 16'h0000, 8'hFF, 1'b0, 1'b0, 16'h0000, 4'b0011}, // R1 const carry
    '{3'd2, 3'd5, 16'hF0F0, 16'h0FF0, 8'h00, 1'b0, 1'b0, 16'h00F0, 4'b0000}, // R1 code 5 passes
    '{3'd3, 3'd0, 16'h00FF, 16'h0F00, 8'h00, 1'b0, 1'b1, 16'hF000, 4'b0100}, // R5 NOR
    '{3'd4, 3'd0, 16'hAAAA, 16'hAAAA, 8'h00, 1'b0, 1'b1, 16'h0000, 4'b0010}, // R5 XOR
    '{3'd2, 3'd0, 16'hFFFF, 16'h8000, 8'h00, 1'b0, 1'b1, 16'h8000, 4'b0100}, // R5 AND
    '{3'd5, 3'd0, 16'h8001, 16'h0000, 8'h00, 1'b0, 1'b0, 16'h0002, 4'b0001}, // R6 left
    '{3'd5, 3'd0, 16'h8001, 16'h0000, 8'h00, 1'b1, 1'b0, 16'h4000, 4'b0001}, // R6 right
    '{3'd5, 3'd0, 16'h0001, 16'h0000, 8'h00, 1'b1, 1'b0, 16'h0000, 4'b0011}, // R6 to zero
    '{3'd6, 3'd0, 16'h8001, 16'h0000, 8'h00, 1'b0, 1'b0, 16'h0003, 4'b0001}, // R7 left
    '{3'd6, 3'd0, 16'h8001, 16'h0000, 8'h00, 1'b1, 1'b0, 16'hC000, 4'b0101}, // R7 right
    '{3'd6, 3'd0, 16'h0002, 16'h0000, 8'h00, 1'b1, 1'b0, 16'h0001, 4'b0000}, // R7 no carry
    '{3'd7, 3'd0, 16'h1234, 16'h5678, 8'h00, 1'b0, 1'b1, 16'h0000, 4'b0010}  // R8 code 7
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] a_i = '0, b_i = '0;
  logic [2:0]  fn_i = '0, bmod_i = '0;
  logic [7:0]  const_i = '0;
  logic        dir_i = 1'b0, cin_i = 1'b0, flag_en_i = 1'b0;
  logic [15:0] result_o;
  logic [3:0]  flags_o, status_o;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk_i = ~clk_i;

  alu16 u_alu16 (
    .clk_i, .rst_ni, .a_i, .b_i, .fn_i, .bmod_i, .const_i,
    .dir_i, .cin_i, .flag_en_i, .result_o, .flags_o, .status_o
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    fn_i = v.fn; bmod_i = v.bm; a_i = v.a; b_i = v.b;
    const_i = v.k; dir_i = v.dir; cin_i = v.cin;
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R9 reset state
    drive(VECS[1]);
    flag_en_i = 1'b1;
    repeat (2) @(posedge clk_i);
    #1 check("R9 reset", 16'(status_o), 16'h0);
    @(negedge clk_i) rst_ni = 1'b1;
    flag_en_i = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      drive(VECS[i]);
      #1;
      check($sformatf("R1-table vec %0d result", i), result_o, VECS[i].exp_r);
      check($sformatf("R8 vec %0d flags", i), 16'(flags_o), 16'(VECS[i].exp_f));
    end

    // R9 load, hold, reload
    @(negedge clk_i);
    drive(VECS[1]);
    flag_en_i = 1'b1;
    @(posedge clk_i); #1;
    check("R9 load", 16'(status_o), 16'h0003);
    @(negedge clk_i);
    drive(VECS[2]);
    flag_en_i = 1'b0;
    @(posedge clk_i); #1;
    check("R9 hold", 16'(status_o), 16'h0003);
    @(negedge clk_i) flag_en_i = 1'b1;
    @(posedge clk_i); #1;
    check("R9 reload", 16'(status_o), 16'h000C);

    // R9 asynchronous reset away from an edge
    @(negedge clk_i);
    #1 rst_ni = 1'b0;
    #0.5 check("R9 async reset", 16'(status_o), 16'h0);
    @(negedge clk_i) rst_ni = 1'b1;

    // R5 carry-in has no effect on a logic op
    @(negedge clk_i);
    fn_i = 3'd2; bmod_i = 3'd0; a_i = 16'h00FF; b_i = 16'h0F0F; cin_i = 1'b0;
    #1 check("R5 cin=0", result_o, 16'h000F);
    cin_i = 1'b1;
    #1 check("R5 cin=1", result_o, 16'h000F);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule